// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block produces the memory addresses for one vector load or store. A single start command supplies a base address, an element count and an addressing mode. The block then walks the elements in order and presents one address per cycle on a valid/ready stream, together with a write flag and the number of the element being accessed. There are three ways to form an address. Strided access adds the element number times a stride to the base. A stride of one covers a contiguous vector, and a larger stride steps down a column of a row-major matrix. Gather (read) and scatter (write) access instead add to the base a per-element offset taken from an offset vector.

An optional per-element enable vector can thin the access. An element whose enable bit is clear costs one internal cycle. It produces no stream beat, but the element number still advances, so the beats that are issued keep their true element numbers. When the consumer holds ready high, issued beats follow each other with no gaps, which keeps memory bursts long. A one-cycle done pulse marks the end of the command.

Top module: `vec_agu`

## Requirements
- R1: After reset, `busy`, `m_valid` and `done` are all low.
- R2: A `start` seen while `busy` is low captures `mode`, `base`, `stride`, `count`, `mask_en`, `mask` and `offs_vec`. A `start` seen while `busy` is high is ignored, and the running command continues unchanged.
- R3: In modes 2'b00 (strided read) and 2'b01 (strided write), element i is issued at address base + i*stride. `m_we` equals bit 0 of the mode.
- R4: In mode 2'b10 (gather), element i is issued at base plus the zero-extended offset in bits [i*OFFW +: OFFW] of `offs_vec`, with `m_we` low.
- R5: In mode 2'b11 (scatter), element i is issued at the same base-plus-offset address as in gather, with `m_we` high.
- R6: When `mask_en` is high, an element whose bit `mask[i]` is 0 produces no beat but still takes one cycle. Issued beats carry their element number on `m_idx` in increasing order. When `mask_en` is low, every element is issued.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_idx` and `m_we` hold steady. With `m_ready` held high, one element is completed every cycle, with no gap between issued beats.
- R8: `done` is high for exactly the one cycle after the last element is completed, whether that element was issued or skipped. `busy` falls at the same time.
- R9: A `count` of 0 issues nothing and raises `done` in the cycle after `start`. A `count` above MAXN is treated as MAXN.
- R10: All address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (accepted only while idle) |
| mode | input | 2 | 00 strided read, 01 strided write, 10 gather, 11 scatter |
| base | input | AW | Base address |
| stride | input | AW | Address step between elements in strided modes |
| count | input | CNTW | Number of elements |
| mask_en | input | 1 | Use `mask` to enable elements |
| mask | input | MAXN | Per-element enable bits |
| offs_vec | input | MAXN*OFFW | Offset vector, element i in bits [i*OFFW +: OFFW] |
| m_valid | output | 1 | Address beat valid |
| m_ready | input | 1 | Consumer accepts the beat |
| m_addr | output | AW | Element address |
| m_we | output | 1 | 1 = write access, 0 = read access |
| m_idx | output | IW | Element number of the beat |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
Two things can happen in the same cycle: a stall on the stream, and the masked skip or final completion that decides `done`. A stall caused by low `m_ready` must freeze the address and the element number. A skipped element, by contrast, advances the element number with no beat at all. The bench provokes this by driving `m_ready` at random while the enable pattern is sparse, and by placing masked elements last. It judges each beat against an expected element list, checks that a stalled beat is held unchanged, and counts the cycles to `done` when ready is held high. The bench also pulses `start` in the middle of a command and checks that the running command is not disturbed.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    MD_LOAD    = 2'b00,
    MD_STORE   = 2'b01,
    MD_GATHER  = 2'b10,
    MD_SCATTER = 2'b11
  } vagu_mode_e;
endpackage

// File: rtl/vagu_seq.sv
// Element counter: walks elements, applies enables, produces done.
module vagu_seq #(
  parameter int MAXN = 16,
  localparam int IW = $clog2(MAXN),
  localparam int CW = $clog2(MAXN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   cnt_in,
  input  logic            mask_en,
  input  logic [MAXN-1:0] mask_in,
  input  logic            ready,
  output logic            busy,
  output logic [IW-1:0]   idx,
  output logic            act,
  output logic            adv,
  output logic            go,
  output logic            done
);
  logic [CW-1:0]   cnt_q;
  logic [MAXN-1:0] en_q;
  logic            last;

  assign go   = start && !busy;
  assign act  = busy && en_q[idx];
  assign adv  = busy && (!en_q[idx] || ready);
  assign last = (CW'(idx) + CW'(1)) == cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      cnt_q <= '0;
      en_q  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        cnt_q <= cnt_in;
        en_q  <= mask_en ? mask_in : '1;
        idx   <= '0;
        if (cnt_in == '0) done <= 1'b1;
        else              busy <= 1'b1;
      end else if (adv) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vagu_addr.sv
// Address former: strided accumulator or base plus per-element offset.
module vagu_addr #(
  parameter int AW   = 32,
  parameter int OFFW = 16,
  parameter int MAXN = 16,
  localparam int IW  = $clog2(MAXN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 adv,
  input  vagu_pkg::vagu_mode_e mode_in,
  input  logic [AW-1:0]        base_in,
  input  logic [AW-1:0]        stride_in,
  input  logic [MAXN*OFFW-1:0] offs_in,
  input  logic [IW-1:0]        idx,
  output logic [AW-1:0]        addr,
  output logic                 we
);
  vagu_pkg::vagu_mode_e mode_q;
  logic [AW-1:0]        base_q, stride_q, acc_q;
  logic [MAXN*OFFW-1:0] offs_q;
  logic [OFFW-1:0]      offs_arr [MAXN];

  for (genvar g = 0; g < MAXN; g++) begin : g_unpack
    assign offs_arr[g] = offs_q[g*OFFW +: OFFW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= vagu_pkg::MD_LOAD;
      base_q   <= '0;
      stride_q <= '0;
      acc_q    <= '0;
      offs_q   <= '0;
    end else if (go) begin
      mode_q   <= mode_in;
      base_q   <= base_in;
      stride_q <= stride_in;
      acc_q    <= base_in;
      offs_q   <= offs_in;
    end else if (adv) begin
      acc_q <= acc_q + stride_q;
    end
  end

  assign addr = mode_q[1] ? base_q + AW'(offs_arr[idx]) : acc_q;
  assign we   = mode_q[0];
endmodule

// File: rtl/vec_agu.sv
module vec_agu #(
  parameter int AW   = 32,
  parameter int OFFW = 16,
  parameter int MAXN = 16,
  parameter int CNTW = 8,
  localparam int IW  = $clog2(MAXN),
  localparam int CW  = $clog2(MAXN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        stride,
  input  logic [CNTW-1:0]      count,
  input  logic                 mask_en,
  input  logic [MAXN-1:0]      mask,
  input  logic [MAXN*OFFW-1:0] offs_vec,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [AW-1:0]        m_addr,
  output logic                 m_we,
  output logic [IW-1:0]        m_idx,
  output logic                 busy,
  output logic                 done
);
  logic [CW-1:0] cnt_eff;
  logic          act, adv, go;

  assign cnt_eff = (count > CNTW'(MAXN)) ? CW'(MAXN) : CW'(count);

  vagu_seq #(.MAXN(MAXN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_eff),
    .mask_en(mask_en), .mask_in(mask), .ready(m_ready),
    .busy(busy), .idx(m_idx), .act(act), .adv(adv), .go(go), .done(done)
  );

  vagu_addr #(.AW(AW), .OFFW(OFFW), .MAXN(MAXN)) u_addr (
    .clk(clk), .rst_n(rst_n), .go(go), .adv(adv),
    .mode_in(vagu_pkg::vagu_mode_e'(mode)), .base_in(base),
    .stride_in(stride), .offs_in(offs_vec), .idx(m_idx),
    .addr(m_addr), .we(m_we)
  );

  assign m_valid = act;
endmodule

// File: rtl/vec_agu_chk.sv
module vec_agu_chk #(
  parameter int AW   = 32,
  parameter int MAXN = 16,
  parameter int CNTW = 8,
  localparam int IW  = $clog2(MAXN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [CNTW-1:0] count,
  input logic            m_valid,
  input logic            m_ready,
  input logic [AW-1:0]   m_addr,
  input logic            m_we,
  input logic [IW-1:0]   m_idx,
  input logic            busy,
  input logic            done
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_idx) && $stable(m_we));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_idx_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready |=> !m_valid || (m_idx > $past(m_idx)));
  p_start_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (count != '0) |=> busy);
  p_zero_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (count == '0) |=> done && !busy);
endmodule

bind vec_agu vec_agu_chk #(.AW(AW), .MAXN(MAXN), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .count(count),
  .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_we(m_we),
  .m_idx(m_idx), .busy(busy), .done(done)
);

// File: tb/vec_agu_test.sv
module vec_agu_test;
  localparam int AW = 32, OFFW = 16, MAXN = 16, CNTW = 8, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mask_en = 1'b0, m_ready = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [AW-1:0] base = '0, stride = '0;
  logic [CNTW-1:0] count = '0;
  logic [MAXN-1:0] mask = '0;
  logic [MAXN*OFFW-1:0] offs_vec = '0;
  logic m_valid, m_we, busy, done;
  logic [AW-1:0] m_addr;
  logic [IW-1:0] m_idx;

  int errs = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  vec_agu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .count(count), .mask_en(mask_en), .mask(mask),
    .offs_vec(offs_vec), .m_valid(m_valid), .m_ready(m_ready),
    .m_addr(m_addr), .m_we(m_we), .m_idx(m_idx), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [1:0] md, input logic [AW-1:0] b,
      input logic [AW-1:0] s, input int i, input logic [MAXN*OFFW-1:0] ov);
    if (md[1]) return b + AW'(ov[i*OFFW +: OFFW]);
    return b + s * AW'(i);
  endfunction

  task automatic run_op(input logic [1:0] md, input logic [AW-1:0] b, input logic [AW-1:0] s,
      input int cnt, input bit men, input logic [MAXN-1:0] mk, input logic [MAXN*OFFW-1:0] ov,
      input int rdy_pct, input bit poke);
    int exp_list[$];
    int eff, j, k;
    bit stall_prev;
    logic [AW-1:0] pa;
    logic [IW-1:0] pi;
    string rq;
    rq = md[1] ? (md[0] ? "R5" : "R4") : "R3";
    eff = (cnt > MAXN) ? MAXN : cnt;
    for (int i = 0; i < eff; i++) if (!men || mk[i]) exp_list.push_back(i);
    @(negedge clk);
    mode = md; base = b; stride = s; count = CNTW'(cnt); mask_en = men; mask = mk;
    offs_vec = ov; start = 1'b1;
    j = 0; k = 0; stall_prev = 1'b0; pa = '0; pi = '0;
    forever begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin start = 1'b1; base = ~b; count = 8'd1; end
      else start = 1'b0;
      if (done) break;
      if (k > 400) begin check(1'b0, "R8 timeout", 64'(k), 64'(eff + 1)); break; end
      if (stall_prev)
        check(m_valid && m_addr == pa && m_idx == pi, "R7 stall hold", 64'(m_addr), 64'(pa));
      m_ready = (($urandom % 100) < rdy_pct);
      stall_prev = m_valid && !m_ready;
      pa = m_addr; pi = m_idx;
      if (m_valid && m_ready) begin
        if (j < exp_list.size()) begin
          check(m_idx == IW'(exp_list[j]), "R6 element number", 64'(m_idx), 64'(exp_list[j]));
          check(m_addr == exp_addr(md, b, s, exp_list[j], ov), rq, 64'(m_addr),
                64'(exp_addr(md, b, s, exp_list[j], ov)));
          check(m_we == md[0], rq, 64'(m_we), 64'(md[0]));
        end else check(1'b0, "R6 extra beat", 64'(j), 64'(exp_list.size()));
        j++;
      end
    end
    start = 1'b0;
    check(j == exp_list.size(), "R6 beat count", 64'(j), 64'(exp_list.size()));
    check(!busy, "R8 busy low at done", 64'(busy), 64'd0);
    if (rdy_pct >= 100)
      check(k == eff + 1, "R7 R8 done timing", 64'(k), 64'(eff + 1));
    @(negedge clk);
    check(!done, "R8 done single cycle", 64'(done), 64'd0);
    m_ready = 1'b0;
  endtask

  function automatic logic [MAXN*OFFW-1:0] rand_offs();
    logic [MAXN*OFFW-1:0] v;
    for (int i = 0; i < MAXN; i++) v[i*OFFW +: OFFW] = OFFW'($urandom);
    return v;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", 64'(cyc), 64'd150000);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!busy && !m_valid && !done, "R1 reset state", {busy, m_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !m_valid && !done, "R1 after release", {busy, m_valid, done}, 64'd0);

    run_op(2'b00, 32'h1000, 32'd4, 8, 1'b0, '0, '0, 100, 1'b0);        // R3 R7
    run_op(2'b01, 32'h8000, 32'h40, 16, 1'b0, '0, '0, 50, 1'b0);       // R3 R7
    run_op(2'b10, 32'h2000_0000, 32'd0, 10, 1'b0, '0, rand_offs(), 60, 1'b0); // R4
    run_op(2'b11, 32'h0300_0000, 32'd0, 16, 1'b1, 16'hA5A5, rand_offs(), 100, 1'b0); // R5 R6
    run_op(2'b10, 32'h10, 32'd0, 12, 1'b1, 16'h0801, rand_offs(), 40, 1'b0); // R6 skip last
    run_op(2'b00, 32'h40, 32'd4, 5, 1'b1, 16'h0000, '0, 100, 1'b0);    // R6 all skipped
    run_op(2'b00, 32'h40, 32'd4, 0, 1'b0, '0, '0, 100, 1'b0);          // R9 zero count
    run_op(2'b01, 32'h500, 32'd2, 20, 1'b0, '0, '0, 100, 1'b0);        // R9 clamp
    run_op(2'b00, 32'hFFFF_FFF0, 32'd8, 6, 1'b0, '0, '0, 100, 1'b0);   // R10 stride wrap
    run_op(2'b11, 32'hFFFF_FFFF, 32'd0, 4, 1'b0, '0, {MAXN{16'h0010}}, 70, 1'b0); // R10
    run_op(2'b00, 32'h9000, 32'd16, 8, 1'b0, '0, '0, 100, 1'b1);       // R2 start ignored

    for (int t = 0; t < 40; t++)
      run_op(2'($urandom), $urandom, $urandom % 64, int'($urandom % (MAXN + 4)),
             1'($urandom), MAXN'($urandom), rand_offs(), 30 + int'($urandom % 71), 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule